// File: doc/BRIEF.md
# DS1 Extended Superframe Transmit Framing-Bit Inserter

This block produces the transmit bit stream of a DS1 link running the Extended Superframe format. A serial payload at 1.544 Mbit/s arrives one bit per clock-enable pulse. A multiframe strobe marks the first bit of each 24-frame group. The block tracks where each bit sits in the 193-bit frame and the 24-frame multiframe. It replaces the first bit of every frame with a framing bit and passes every other bit through unchanged.

Each framing bit is one of three kinds. In odd frames it is a data-link bit, driven to one because this block has no link input. Frames 4, 8, 12, 16, 20 and 24 carry the alignment pattern. Frames 2, 6, 10, 14, 18 and 22 carry the six check bits of the previous multiframe. The check is CRC-6 over the whole multiframe, with every framing position counted as a one. A control input can instead hand all framing positions to an external serial input, unchanged. That path is only honoured when the backplane runs at the native rate. Otherwise the block keeps generating the framing bits itself.

Top module: `esf_fbit_inserter`

## Requirements
- R1: After reset, tx_out and tx_fmark are 0. The first enabled bit is treated as bit 0 of frame 1, even without a strobe.
- R2: A bit enabled together with mf_start is the framing bit of frame 1, and tx_fmark is 1 for it. Positions then advance one per enabled bit, with bit indices 0..192 and frames 1..24.
- R3: At every non-framing position, tx_out equals pay_in of that enabled bit.
- R4: With internal generation, the framing bits of odd frames (1, 3, ..., 23) are 1.
- R5: With internal generation, the framing bits of frames 4, 8, 12, 16, 20, 24 are 0, 0, 1, 0, 1, 1 in that order.
- R6: The check value is CRC-6 with generator x^6+x+1. It is computed most significant bit first over the 4632 bits of a multiframe, starting from zero, with framing positions taken as 1. Its bits are sent, most significant first, in frames 2, 6, 10, 14, 18, 22 of the next multiframe. A multiframe cut short by an early strobe does not replace the stored value.
- R7: Before any multiframe has completed since reset, the check-bit positions carry 0.
- R8: When fbit_src=1 and native_rate=1, every framing position outputs ext_in of that enabled bit.
- R9: When fbit_src=1 and native_rate=0, framing bits are generated internally as in R4 to R6.
- R10: In cycles without bit_en the outputs hold their values, and pay_in, ext_in and mf_start have no effect.
- R11: The framing values actually sent, including external ones, do not change the check value carried to the next multiframe.
- R12: The output bit for an enabled input appears one clock after the bit_en cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Clock enable; one serial bit per pulse |
| mf_start | input | 1 | Marks the current bit as the first bit of a multiframe |
| pay_in | input | 1 | Serial payload bit |
| ext_in | input | 1 | External serial bit supplying framing bits |
| fbit_src | input | 1 | 0 selects internal framing bits, 1 selects external |
| native_rate | input | 1 | 1 when the backplane runs at 1.544 Mbit/s |
| tx_out | output | 1 | Registered transmit bit |
| tx_fmark | output | 1 | Registered flag, 1 when tx_out is a framing bit |

## Verification
Assertions check the following on every cycle: the outputs hold without an enable, payload bits pass through, external framing bits pass through, data-link bits are ones, a strobe lands on a framing position, the stored check value changes only at the end of a multiframe, and the position counters stay in range. Only the bench scenarios can show that the CRC-6 value matches an independent division of the multiframe contents. The scenarios also show that the alignment pattern appears in the right frames and that the first multiframe carries zero check bits. The remaining scenario-only behaviours are the fallback to internal generation at a non-native rate, that external framing values leave the next check value untouched, and realignment to an early strobe.

// File: rtl/esf_fbit_pkg.sv
package esf_fbit_pkg;

    // Alignment pattern, bit k is the value sent in the k-th pattern frame (4, 8, ...)
    localparam logic [5:0] ESF_FPS_REV = 6'b110100;
    // Low-order terms of x^6 + x + 1
    localparam logic [5:0] CRC6_POLY   = 6'b000011;

    typedef enum logic [1:0] {
        FK_LINK = 2'd0,
        FK_CRC  = 2'd1,
        FK_FPS  = 2'd2
    } fkind_e;

    // Frame phase is the 0-based frame index modulo 4
    function automatic fkind_e classify(input logic [1:0] phase);
        case (phase)
            2'd1:    return FK_CRC;
            2'd3:    return FK_FPS;
            default: return FK_LINK;
        endcase
    endfunction

endpackage

// File: rtl/esf_pos_counter.sv
module esf_pos_counter #(
    parameter int FRAME_BITS = 193,
    parameter int MF_FRAMES  = 24,
    localparam int FRM_W     = $clog2(MF_FRAMES),
    localparam int BIT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mf_start,
    output logic [FRM_W-1:0] cur_frame,
    output logic             is_fbit,
    output logic             mf_first,
    output logic             mf_last
);

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic [BIT_W-1:0] bitn;
    } pos_t;

    pos_t pos_q, pos_d, cur;

    always_comb begin
        cur   = mf_start ? '0 : pos_q;
        pos_d = pos_q;
        if (bit_en) begin
            if (cur.bitn == BIT_W'(FRAME_BITS - 1)) begin
                pos_d.bitn  = '0;
                pos_d.frame = (cur.frame == FRM_W'(MF_FRAMES - 1)) ? '0 : cur.frame + 1'b1;
            end else begin
                pos_d.bitn  = cur.bitn + 1'b1;
                pos_d.frame = cur.frame;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign cur_frame = cur.frame;
    assign is_fbit   = (cur.bitn == '0);
    assign mf_first  = (cur == '0);
    assign mf_last   = (cur.frame == FRM_W'(MF_FRAMES - 1)) && (cur.bitn == BIT_W'(FRAME_BITS - 1));

    // R2: stored position never leaves the frame or multiframe
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pos_q.bitn) < FRAME_BITS) && (int'(pos_q.frame) < MF_FRAMES));

    // R10: without an enable the position is frozen
    p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos_q));

endmodule

// File: rtl/esf_crc6_engine.sv
module esf_crc6_engine #(
    parameter int             CRC_W = 6,
    parameter logic [CRC_W-1:0] POLY = esf_fbit_pkg::CRC6_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mf_first,
    input  logic             mf_last,
    input  logic             is_fbit,
    input  logic             data_in,
    output logic [CRC_W-1:0] crc_prev
);

    typedef struct packed {
        logic [CRC_W-1:0] run;
        logic [CRC_W-1:0] hold;
    } crc_t;

    crc_t crc_q, crc_d;
    logic [CRC_W-1:0] start_v, stepped;
    logic             din, fb;

    always_comb begin
        start_v = mf_first ? '0 : crc_q.run;
        din     = is_fbit ? 1'b1 : data_in;
        fb      = start_v[CRC_W-1] ^ din;
        stepped = {start_v[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        crc_d   = crc_q;
        if (bit_en) begin
            crc_d.run = stepped;
            if (mf_last) crc_d.hold = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_prev = crc_q.hold;

    // R6: the value sent in the check slots changes only when a multiframe completes
    p_hold_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && mf_last) |=> $stable(crc_q.hold));

endmodule

// File: rtl/esf_fbit_select.sv
module esf_fbit_select #(
    parameter int CRC_W = 6,
    parameter int FRM_W = 5
) (
    input  logic [FRM_W-1:0] cur_frame,
    input  logic [CRC_W-1:0] crc_prev,
    input  logic             use_ext,
    input  logic             ext_in,
    output logic             fbit
);
    import esf_fbit_pkg::*;

    localparam int K_W = FRM_W - 2;

    logic [CRC_W-1:0] crc_rev;
    logic [K_W-1:0]   slot;

    // Reverse so that slot 0 picks the most significant check bit
    for (genvar i = 0; i < CRC_W; i++) begin : g_rev
        assign crc_rev[i] = crc_prev[CRC_W-1-i];
    end

    assign slot = cur_frame[FRM_W-1:2];

    always_comb begin
        if (use_ext) begin
            fbit = ext_in;
        end else begin
            case (classify(cur_frame[1:0]))
                FK_CRC:  fbit = crc_rev[slot];
                FK_FPS:  fbit = ESF_FPS_REV[slot];
                default: fbit = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/esf_fbit_inserter.sv
module esf_fbit_inserter #(
    parameter int FRAME_BITS = 193,
    parameter int MF_FRAMES  = 24,
    parameter int CRC_W      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mf_start,
    input  logic pay_in,
    input  logic ext_in,
    input  logic fbit_src,
    input  logic native_rate,
    output logic tx_out,
    output logic tx_fmark
);

    localparam int FRM_W = $clog2(MF_FRAMES);

    typedef struct packed {
        logic data;
        logic fmark;
    } txo_t;

    txo_t             out_q, out_d;
    logic [FRM_W-1:0] cur_frame;
    logic             is_fbit, mf_first, mf_last, use_ext, fbit;
    logic [CRC_W-1:0] crc_prev;

    assign use_ext = fbit_src & native_rate;

    esf_pos_counter #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mf_start(mf_start),
        .cur_frame(cur_frame), .is_fbit(is_fbit), .mf_first(mf_first), .mf_last(mf_last)
    );

    esf_crc6_engine #(.CRC_W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mf_first(mf_first),
        .mf_last(mf_last), .is_fbit(is_fbit), .data_in(pay_in), .crc_prev(crc_prev)
    );

    esf_fbit_select #(.CRC_W(CRC_W), .FRM_W(FRM_W)) u_sel (
        .cur_frame(cur_frame), .crc_prev(crc_prev), .use_ext(use_ext),
        .ext_in(ext_in), .fbit(fbit)
    );

    always_comb begin
        out_d = out_q;
        if (bit_en) begin
            out_d.data  = is_fbit ? fbit : pay_in;
            out_d.fmark = is_fbit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tx_out   = out_q.data;
    assign tx_fmark = out_q.fmark;

    // R10: outputs hold when no bit is enabled
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_out) && $stable(tx_fmark));

    // R3 / R12: payload bits appear unchanged one clock later
    p_payload_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !is_fbit |=> !tx_fmark && (tx_out == $past(pay_in)));

    // R8: external framing bits pass through at the native rate
    p_ext_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && is_fbit && fbit_src && native_rate |=> tx_fmark && (tx_out == $past(ext_in)));

    // R4: data-link framing bits are ones under internal generation
    p_link_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && is_fbit && !use_ext && !cur_frame[0] |=> tx_out);

    // R2: a strobe always lands on a framing position
    p_strobe_fbit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && mf_start |=> tx_fmark);

endmodule

// File: tb/esf_fbit_inserter_bench.sv
`timescale 1ns/1ps
module esf_fbit_inserter_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, bit_en, mf_start, pay_in, ext_in, fbit_src, native_rate;
    logic tx_out, tx_fmark;

    esf_fbit_inserter u_esf_fbit_inserter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mf_start(mf_start),
        .pay_in(pay_in), .ext_in(ext_in), .fbit_src(fbit_src),
        .native_rate(native_rate), .tx_out(tx_out), .tx_fmark(tx_fmark)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int         m_frame = 0, m_bit = 0;
    logic [5:0] m_rem = '0, m_prev = '0;
    logic [15:0] lf = 16'hACE1;
    logic       last_o = 1'b0, last_f = 1'b0;
    string      crc_tag = "R6";
    bit         fps_ref [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    function automatic logic [5:0] div_step(input logic [5:0] rem, input logic din);
        logic [6:0] t;
        t = {rem, din};
        if (t[6]) t = t ^ 7'h43;
        return t[5:0];
    endfunction

    function automatic logic rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic check(input string tag, input logic go, input logic eo,
                         input logic gf, input logic ef);
        n_vec++;
        if (go !== eo || gf !== ef) begin
            n_bad++;
            $display("FAIL %s: got out=%0b fmark=%0b, expected out=%0b fmark=%0b (frame %0d bit %0d)",
                     tag, go, gf, eo, ef, m_frame + 1, m_bit);
        end
    endtask

    // Apply one enabled bit; called at a falling edge, checks at the next one
    task automatic push(input logic mf, input logic pay, input logic ext, input string force_tag);
        logic  isf, exp;
        int    n;
        string tag;
        logic [5:0] tmp;
        if (mf) begin m_frame = 0; m_bit = 0; end
        isf = (m_bit == 0);
        n   = m_frame + 1;
        if (!isf) begin
            exp = pay; tag = "R3";
        end else if (fbit_src && native_rate) begin
            exp = ext; tag = "R8";
        end else begin
            if (n % 2 == 1)      begin exp = 1'b1;                    tag = "R4"; end
            else if (n % 4 == 2) begin exp = m_prev[5 - (n - 2) / 4]; tag = crc_tag; end
            else                 begin exp = fps_ref[n / 4 - 1];      tag = "R5"; end
            if (fbit_src) tag = {"R9/", tag};
        end
        if (force_tag != "") tag = force_tag;
        if (m_frame == 0 && m_bit == 0) m_rem = '0;
        m_rem = div_step(m_rem, isf ? 1'b1 : pay);
        if (m_frame == 23 && m_bit == 192) begin
            tmp = m_rem;
            repeat (6) tmp = div_step(tmp, 1'b0);
            m_prev = tmp;
        end
        mf_start = mf; pay_in = pay; ext_in = ext; bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({tag, "/R12"}, tx_out, exp, tx_fmark, isf);
        last_o = exp; last_f = isf;
        if (m_bit == 192) begin
            m_bit = 0;
            m_frame = (m_frame == 23) ? 0 : m_frame + 1;
        end else begin
            m_bit++;
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            bit_en = 1'b0; mf_start = rnd(); pay_in = rnd(); ext_in = rnd();
            @(posedge clk);
            @(negedge clk);
            check("R10", tx_out, last_o, tx_fmark, last_f);
        end
        mf_start = 1'b0;
    endtask

    task automatic run_mf(input logic strobe, input int gap_every);
        for (int i = 0; i < 24 * 193; i++) begin
            push(strobe && i == 0, rnd(), rnd(), (strobe && i == 0) ? "R2" : "");
            if (gap_every > 0 && i % gap_every == gap_every - 1) idle(2);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bit_en = 1'b0; mf_start = 1'b0; pay_in = 1'b0; ext_in = 1'b0;
        fbit_src = 1'b0; native_rate = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", tx_out, 1'b0, tx_fmark, 1'b0);
        // First bit without strobe must be frame 1 framing bit
        push(1'b0, 1'b0, 1'b0, "R1");
        crc_tag = "R7";
        for (int i = 1; i < 24 * 193; i++) push(1'b0, rnd(), rnd(), "");
    endtask

    task automatic t_internal();
        crc_tag = "R7";
        run_mf(1'b1, 0);   // first slots still zero, previous not complete before this? no: completed
        crc_tag = "R6";
        run_mf(1'b1, 0);
    endtask

    task automatic t_external();
        fbit_src = 1'b1; native_rate = 1'b1;
        run_mf(1'b1, 0);
        fbit_src = 1'b0;
        crc_tag = "R11";
        run_mf(1'b1, 0);
        crc_tag = "R6";
    endtask

    task automatic t_fallback();
        fbit_src = 1'b1; native_rate = 1'b0;
        run_mf(1'b1, 0);
        fbit_src = 1'b0; native_rate = 1'b1;
    endtask

    task automatic t_gaps();
        run_mf(1'b1, 37);
    endtask

    task automatic t_realign();
        for (int i = 0; i < 1000; i++) push(i == 0, rnd(), rnd(), "");
        run_mf(1'b1, 0);
        run_mf(1'b1, 0);
    endtask

    initial begin
        t_reset();
        // after t_reset one full multiframe is complete, so its CRC is now live
        crc_tag = "R6";
        run_mf(1'b1, 0);
        run_mf(1'b1, 0);
        t_external();
        t_fallback();
        t_gaps();
        t_realign();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule